// File: doc/BRIEF.md
# Interleaved Recompute Linear Array

A one-dimensional chain of identical arithmetic cells that checks itself while it computes. A token `y` passes through N coefficient stages. Each stage applies f(x, v) = v + x·v, wrapped to W bits. A leading cell, numbered 0, turns every token into a two-slot pair. The first slot (main) carries the running value. The second slot (redo) carries that value already pushed one stage ahead. Each cell selects between two coefficients by slot: its own coefficient for the main slot, and the next stage's coefficient for the redo slot. The result is that cell k+1, one cycle later, repeats in its main slot the work that cell k did in its redo slot.

A comparator between each neighbouring pair of cells flags any difference. A fault in one cell therefore shows up on the flags beside it. The cells hold no data beyond their single pipeline register, and one horizontal path carries both slots. Because each token uses two slots, a new token may enter at most every second cycle. The host holds `y_in` steady for the cycle after the strobe and keeps the coefficients stable while tokens are in flight.

Top module: `dup_chain_array`

## Requirements
- R1: For a token y with stage coefficients x1..xN, where xk sits at `coef[(k-1)*W +: W]`, the result is A_N, with A_0 = y and A_k = A_(k-1) + xk·A_(k-1).
- R2: `strobe` high marks a new token. `y_in` is held for the following cycle. `strobe` is never high on two consecutive cycles, so tokens may enter every second cycle.
- R3: A token's result appears with `res_vld` high for exactly one cycle, N+1 cycles after its strobe cycle. `res_vld` is never high on two consecutive cycles, and results leave in entry order.
- R4: While `strobe` stays low, changes on `y_in` produce no `res_vld` and no mismatch flag.
- R5: Cell e uses xe in the main slot and x(e+1) in the redo slot. Cell 0 uses 0 in the main slot, and cell N uses 0 in the redo slot. Flag bit k compares the redo result of cell k with the main result of cell k+1.
- R6: Flag bit k is registered and pulses for one cycle, k+3 cycles after the strobe of the token it judges. With no fault, no flag ever rises.
- R7: While reset is held and directly after it, `res_vld`, `res_data` and `mismatch` are all zero.
- R8: If cell e produces a constant v regardless of its inputs, flag bit e-1 rises when v differs from the true A_e. No flag bit below e-1 ever rises. The remaining bits follow the pair relation of R5 applied to the corrupted stream.
- R9: All products and sums wrap modulo 2^W. For example, a coefficient of all ones maps any value to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe | input | 1 | Marks the cycle that carries a new token |
| y_in | input | W | Token value, held for two cycles |
| coef | input | N*W | Stage coefficients, x1 in the lowest W bits |
| res_vld | output | 1 | Result valid pulse |
| res_data | output | W | Result of the chain |
| mismatch | output | N | Per-pair registered disagreement flags |

## Verification
The hardest situation to reach is a cell that computes wrongly, because a healthy design never disagrees with itself and no port can make it do so. The bench therefore forces the function output of one chosen cell to a constant. This is done at the head, the middle and the tail of the chain, and includes a stuck-at-zero case that leaves only the upstream flag raised. Each time, the bench compares the exact flag pattern and its timing with a token-level model of the two slots.

// File: rtl/dcx_pkg.sv
package dcx_pkg;
    typedef enum logic {
        SLOT_REDO = 1'b0,
        SLOT_MAIN = 1'b1
    } slot_e;
endpackage

// File: rtl/dcx_cell.sv
module dcx_cell
    import dcx_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  slot_e        in_slot,
    input  logic [W-1:0] in_data,
    input  logic [W-1:0] coef_main,
    input  logic [W-1:0] coef_redo,
    output logic         out_vld,
    output slot_e        out_slot,
    output logic [W-1:0] out_data
);
    typedef struct packed {
        logic         vld;
        slot_e        slot;
        logic [W-1:0] data;
    } cell_t;

    cell_t        st_d, st_q;
    logic [W-1:0] coef_sel;
    logic [W-1:0] prod;
    logic [W-1:0] f_val;

    // coefficient mux driven by slot parity
    assign coef_sel = (in_slot == SLOT_MAIN) ? coef_main : coef_redo;
    assign prod     = coef_sel * in_data;
    assign f_val    = in_data + prod;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            st_d.slot = in_slot;
            st_d.data = f_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld  = st_q.vld;
    assign out_slot = st_q.slot;
    assign out_data = st_q.data;

    // R5: a main slot is always followed by its redo slot
    p_redo_follows_main_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && st_q.slot == SLOT_MAIN) |=> (st_q.vld && st_q.slot == SLOT_REDO));
endmodule

// File: rtl/dcx_pair_chk.sv
module dcx_pair_chk
    import dcx_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         up_vld,
    input  slot_e        up_slot,
    input  logic [W-1:0] up_data,
    input  logic         dn_vld,
    input  slot_e        dn_slot,
    input  logic [W-1:0] dn_data,
    output logic         flag
);
    typedef struct packed {
        logic flag;
    } chk_t;

    chk_t chk_d, chk_q;
    logic both;

    assign both = up_vld && (up_slot == SLOT_REDO) && dn_vld && (dn_slot == SLOT_MAIN);

    always_comb begin
        chk_d      = chk_q;
        chk_d.flag = both && (up_data != dn_data);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chk_q <= '0;
        else        chk_q <= chk_d;
    end

    assign flag = chk_q.flag;

    // R6: a flag is a single-cycle pulse
    p_flag_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flag |=> !flag);
    // R5: a flag only judges a cycle where the upstream cell held a redo slot
    p_flag_redo_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flag |-> $past(up_slot == SLOT_REDO));
endmodule

// File: rtl/dup_chain_array.sv
module dup_chain_array
    import dcx_pkg::*;
#(
    parameter int W = 16,
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           strobe,
    input  logic [W-1:0]   y_in,
    input  logic [N*W-1:0] coef,
    output logic           res_vld,
    output logic [W-1:0]   res_data,
    output logic [N-1:0]   mismatch
);
    localparam int NCELL = N + 1;

    typedef struct packed {
        logic stb_prev;
    } top_t;

    top_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.stb_prev = strobe;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic         c_vld  [NCELL];
    slot_e        c_slot [NCELL];
    logic [W-1:0] c_data [NCELL];

    generate
        for (genvar e = 0; e < NCELL; e++) begin : g_cell
            logic         i_vld;
            slot_e        i_slot;
            logic [W-1:0] i_data;
            logic [W-1:0] cm;
            logic [W-1:0] cr;

            if (e == 0) begin : g_head
                assign i_vld  = strobe | st_q.stb_prev;
                assign i_slot = strobe ? SLOT_MAIN : SLOT_REDO;
                assign i_data = y_in;
                assign cm     = '0;
            end else begin : g_body
                assign i_vld  = c_vld[e-1];
                assign i_slot = c_slot[e-1];
                assign i_data = c_data[e-1];
                assign cm     = coef[(e-1)*W +: W];
            end

            if (e == N) begin : g_tail
                assign cr = '0;
            end else begin : g_mid
                assign cr = coef[e*W +: W];
            end

            dcx_cell #(.W(W)) u_cell (
                .clk       (clk),
                .rst_n     (rst_n),
                .in_vld    (i_vld),
                .in_slot   (i_slot),
                .in_data   (i_data),
                .coef_main (cm),
                .coef_redo (cr),
                .out_vld   (c_vld[e]),
                .out_slot  (c_slot[e]),
                .out_data  (c_data[e])
            );
        end

        for (genvar k = 0; k < N; k++) begin : g_pair
            dcx_pair_chk #(.W(W)) u_chk (
                .clk     (clk),
                .rst_n   (rst_n),
                .up_vld  (c_vld[k]),
                .up_slot (c_slot[k]),
                .up_data (c_data[k]),
                .dn_vld  (c_vld[k+1]),
                .dn_slot (c_slot[k+1]),
                .dn_data (c_data[k+1]),
                .flag    (mismatch[k])
            );
        end
    endgenerate

    assign res_vld  = c_vld[N] && (c_slot[N] == SLOT_MAIN);
    assign res_data = c_data[N];

    // R2: tokens are at least two cycles apart
    p_strobe_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);
    // R2: token value held through its redo cycle
    p_y_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> $stable(y_in));
    // R3: results occupy alternate cycles
    p_result_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |=> !res_vld);
endmodule

// File: tb/tb_dup_chain_array.sv
module tb_dup_chain_array;
    localparam int W = 16;
    localparam int N = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           strobe = 1'b0;
    logic [W-1:0]   y_in = '0;
    logic [N*W-1:0] coef = '0;
    logic           res_vld;
    logic [W-1:0]   res_data;
    logic [N-1:0]   mismatch;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dup_chain_array #(.W(W), .N(N)) dut (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .y_in(y_in), .coef(coef),
        .res_vld(res_vld), .res_data(res_data), .mismatch(mismatch)
    );

    task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] fx(input logic [W-1:0] x, input logic [W-1:0] v);
        logic [W-1:0] p;
        p = x * v;
        return v + p;
    endfunction

    // token-level model of both slots; fe < 0 means no fault
    task automatic model(input logic [W-1:0] y, input logic [N*W-1:0] cf, input int fe,
                         input logic [W-1:0] badv, output logic [W-1:0] res, output logic [N-1:0] fl);
        logic [W-1:0] a [N+1];
        logic [W-1:0] b [N+1];
        for (int e = 0; e <= N; e++) begin
            logic [W-1:0] xa, xb, ina, inb;
            xa  = (e == 0) ? '0 : cf[(e-1)*W +: W];
            xb  = (e == N) ? '0 : cf[e*W +: W];
            ina = (e == 0) ? y : a[e-1];
            inb = (e == 0) ? y : b[e-1];
            a[e] = fx(xa, ina);
            b[e] = fx(xb, inb);
            if (e == fe) begin
                a[e] = badv;
                b[e] = badv;
            end
        end
        for (int k = 0; k < N; k++) fl[k] = (b[k] != a[k+1]);
        res = a[N];
    endtask

    // one token, exact timing of result and flags
    task automatic run_token(input logic [W-1:0] y, input logic [W-1:0] exp_res,
                             input logic [N-1:0] exp_fl, input string tag);
        logic [N-1:0] obs_fl;
        int stray_rv, stray_fl;
        obs_fl = '0; stray_rv = 0; stray_fl = 0;
        @(negedge clk);
        strobe = 1'b1;
        y_in   = y;
        for (int cyc = 1; cyc <= N + 6; cyc++) begin
            @(negedge clk);
            if (cyc == 1) strobe = 1'b0;
            if (cyc == N + 1) begin
                check(res_vld == 1'b1, {tag, " R3 res_vld at N+1"}, 64'(res_vld), 64'd1);
                check(res_data == exp_res, {tag, " R1 result"}, 64'(res_data), 64'(exp_res));
            end else if (res_vld) begin
                stray_rv++;
            end
            for (int k = 0; k < N; k++) begin
                if (cyc == k + 3) obs_fl[k] = mismatch[k];
                else if (mismatch[k]) stray_fl++;
            end
        end
        check(stray_rv == 0, {tag, " R3 single res_vld pulse"}, 64'(stray_rv), 64'd0);
        check(obs_fl == exp_fl, {tag, " R6 flag pattern"}, 64'(obs_fl), 64'(exp_fl));
        check(stray_fl == 0, {tag, " R6 flag timing"}, 64'(stray_fl), 64'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(res_vld == 1'b0, "R7 res_vld in reset", 64'(res_vld), 64'd0);
        check(res_data == '0, "R7 res_data in reset", 64'(res_data), 64'd0);
        check(mismatch == '0, "R7 mismatch in reset", 64'(mismatch), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(res_vld == 1'b0 && mismatch == '0, "R7 after reset", 64'({res_vld, mismatch}), 64'd0);
    endtask

    task automatic t_basic();
        logic [W-1:0] r;
        logic [N-1:0] f;
        coef = {16'd2, 16'd7, 16'd5, 16'd3};
        model(16'd11, coef, -1, '0, r, f);
        run_token(16'd11, r, '0, "R1 R5 basic");
        coef = '0;
        run_token(16'h1234, 16'h1234, '0, "R1 zero coefficients");
    endtask

    task automatic t_wrap();
        logic [W-1:0] r;
        logic [N-1:0] f;
        coef = {16'd9, 16'd4, 16'd3, 16'hFFFF};
        run_token(16'hABCD, 16'h0000, '0, "R9 all-ones coefficient");
        coef = {16'd1, 16'd1, 16'd1, 16'd1};
        model(16'hFFFF, coef, -1, '0, r, f);
        check(r == 16'hFFF0, "R9 model wrap value", 64'(r), 64'hFFF0);
        run_token(16'hFFFF, 16'hFFF0, '0, "R9 doubling wrap");
    endtask

    task automatic t_stream();
        logic [W-1:0] ys [4];
        logic [W-1:0] exp_r [4];
        logic [N-1:0] f;
        int got, stray_fl, timing_err;
        ys[0] = 16'd1; ys[1] = 16'd300; ys[2] = 16'h8001; ys[3] = 16'd77;
        coef = {16'd13, 16'd6, 16'hFFFE, 16'd21};
        for (int i = 0; i < 4; i++) model(ys[i], coef, -1, '0, exp_r[i], f);
        got = 0; stray_fl = 0; timing_err = 0;
        for (int cyc = 0; cyc <= 2 * 4 + N + 5; cyc++) begin
            @(negedge clk);
            if (cyc % 2 == 0 && cyc / 2 < 4) begin
                strobe = 1'b1;
                y_in   = ys[cyc / 2];
            end else begin
                strobe = 1'b0;
            end
            if (mismatch != '0) stray_fl++;
            if (res_vld) begin
                if (got < 4) begin
                    check(res_data == exp_r[got], "R3 stream result in order", 64'(res_data), 64'(exp_r[got]));
                    if (cyc != 2 * got + N + 1) timing_err++;
                end
                got++;
            end
        end
        check(got == 4, "R3 stream result count", 64'(got), 64'd4);
        check(timing_err == 0, "R2 R3 back-to-back timing", 64'(timing_err), 64'd0);
        check(stray_fl == 0, "R6 no flag in fault-free stream", 64'(stray_fl), 64'd0);
    endtask

    task automatic t_idle();
        int hits;
        hits = 0;
        for (int cyc = 0; cyc < N + 8; cyc++) begin
            @(negedge clk);
            y_in = 16'(cyc * 977 + 5);
            if (res_vld || mismatch != '0) hits++;
        end
        check(hits == 0, "R4 no strobe no output", 64'(hits), 64'd0);
    endtask

    task automatic t_fault_mid();
        logic [W-1:0] r;
        logic [N-1:0] f;
        coef = {16'd3, 16'd5, 16'd9, 16'd2};
        model(16'd40, coef, 2, 16'h1357, r, f);
        check(f[0] == 1'b0 && f[1] == 1'b1, "R8 model sanity", 64'(f), 64'd2);
        force dut.g_cell[2].u_cell.f_val = 16'h1357;
        run_token(16'd40, r, f, "R8 fault cell 2");
        release dut.g_cell[2].u_cell.f_val;
    endtask

    task automatic t_fault_zero();
        logic [W-1:0] r;
        logic [N-1:0] f;
        coef = {16'd3, 16'd5, 16'd9, 16'd2};
        model(16'd40, coef, 1, 16'h0000, r, f);
        check(f == 4'b0001, "R8 stuck-zero only upstream flag", 64'(f), 64'd1);
        force dut.g_cell[1].u_cell.f_val = 16'h0000;
        run_token(16'd40, r, f, "R8 stuck-zero cell 1");
        release dut.g_cell[1].u_cell.f_val;
    endtask

    task automatic t_fault_tail();
        logic [W-1:0] r;
        logic [N-1:0] f;
        coef = {16'd3, 16'd5, 16'd9, 16'd2};
        model(16'd17, coef, N, 16'hA5A5, r, f);
        check(f == 4'b1000, "R8 tail fault flags last pair only", 64'(f), 64'h8);
        force dut.g_cell[4].u_cell.f_val = 16'hA5A5;
        run_token(16'd17, r, f, "R8 fault cell 4");
        release dut.g_cell[4].u_cell.f_val;
    endtask

    task automatic t_fault_head();
        logic [W-1:0] r;
        logic [N-1:0] f;
        coef = {16'd3, 16'd5, 16'd9, 16'd2};
        model(16'd40, coef, 0, 16'h0F0F, r, f);
        force dut.g_cell[0].u_cell.f_val = 16'h0F0F;
        run_token(16'd40, r, f, "R5 R8 fault cell 0");
        release dut.g_cell[0].u_cell.f_val;
        run_token(16'd40, r == r ? fx(16'd3, fx(16'd5, fx(16'd9, fx(16'd2, 16'd40)))) : '0,
                  '0, "R6 healthy after release");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_wrap();
        t_stream();
        t_idle();
        t_fault_mid();
        t_fault_zero();
        t_fault_tail();
        t_fault_head();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule